// File: doc/BRIEF.md
# Calendar Shadow Read Synchronizer

This block sits on the boundary between a slow calendar clock and a fast bus clock. A calendar core, outside this block, counts subseconds, time and date. This block keeps a copy of each of those three words in the bus domain. Once every two slow-clock periods it carries a refresh event across the clock boundary. On that event it reloads the shadow copies and raises a sync flag. Software may clear the flag, and the flag sets again only on the next refresh.

Software reads the words with a one-cycle strobe and a two-bit word select. The data returns one bus cycle later. A group read in order (subsecond, then time, then date) stays consistent, because each read in the group holds back the refresh of the words that follow it until the date word has been read. A bypass input makes reads return the live calendar words and leaves the hold state alone. Correct operation needs a bus clock at least seven times faster than the slow clock.

The hold logic is a three-state machine:
- `ST_OPEN`: nothing is held.
- `ST_HOLD_TD`: the time and date words are held.
- `ST_HOLD_D`: only the date word is held.

There are three transitions, and each one applies from every state:
- `T_SS_READ` goes to `ST_HOLD_TD`.
- `T_TIME_READ` goes to `ST_HOLD_D`.
- `T_DATE_READ` goes to `ST_OPEN`.

Top module: `cal_shadow_sync`

## Requirements
- R1: With bypass low, a read returns the shadow word chosen by `rd_addr`: 0 is subsecond, 1 is time, 2 is date and 3 reads as zero. The value is zero-extended and appears on `rd_data` one bus cycle after the strobe.
- R2: With bypass high, a read returns the live word as it stands in the cycle of the strobe, with the same selection and latency.
- R3: A refresh happens on every second rising edge of `cal_clk`, counting from the first edge after reset. The shadows load the live words three bus cycles after that slow edge, once the two-flop synchronizer and the edge detector have passed the event on.
- R4: `sync_flag` is set by every refresh. If a clear arrives in the same cycle as a refresh, the set wins.
- R5: A `sync_clr` pulse clears `sync_flag`, and the flag stays low until the next refresh.
- R6: A subsecond read with bypass low holds the time and date shadows. The hold covers a refresh in the very cycle of the read.
- R7: A time read with bypass low holds the date shadow and releases any hold on the time shadow.
- R8: A date read with bypass low releases all holds from the following cycle on. A refresh in the cycle of that date read still skips the date word.
- R9: The subsecond shadow is never held. A refresh that skips held words still updates the unheld ones and still sets `sync_flag`.
- R10: Reads made while bypass is high leave the hold state unchanged.
- R11: After reset the shadows are zero, `sync_flag` and `rd_data` are zero, and nothing is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| cal_clk | input | 1 | Slow calendar clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| live_ss | input | SS_W | Live subsecond word from the calendar core |
| live_time | input | TIME_W | Live time word from the calendar core |
| live_date | input | DATE_W | Live date word from the calendar core |
| bypass | input | 1 | High: reads return live words and do not change the hold state |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | 2 | Word select: 0 subsecond, 1 time, 2 date, 3 none |
| sync_clr | input | 1 | Clears the sync flag |
| rd_data | output | DATA_W | Registered read data |
| sync_flag | output | 1 | Set on every shadow refresh |

## Verification
The hardest case to reach from the ports is a read that lands in the exact bus cycle in which a refresh loads the shadows. Here the hold must apply in that same cycle, and a clear must lose to the set. The bench derives the slow clock from the bus clock, with one slow period every 16 bus cycles, so it knows the refresh cycle in advance. Directed sequences place a subsecond read, a date read and a flag clear on that cycle. Seeded random traffic then covers every other alignment of reads, bypass changes and clears.

// File: rtl/cal_sync_pkg.sv
`timescale 1ns/1ps
package cal_sync_pkg;

    typedef enum logic [1:0] {
        SEL_SUBSEC = 2'd0,
        SEL_TIME   = 2'd1,
        SEL_DATE   = 2'd2,
        SEL_NONE   = 2'd3
    } word_sel_e;

    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_HOLD_TD = 2'd1,
        ST_HOLD_D  = 2'd2
    } hold_state_e;

endpackage

// File: rtl/cal_refresh_sync.sv
`timescale 1ns/1ps
module cal_refresh_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic bus_clk,
    input  logic cal_clk,
    input  logic rst_n,
    output logic refresh_o
);

    // Slow domain: a toggle that changes on every slow edge.
    // Its rising edge marks every second slow period.
    logic cal_tog;

    always_ff @(posedge cal_clk or negedge rst_n) begin
        if (!rst_n) cal_tog <= 1'b0;
        else        cal_tog <= ~cal_tog;
    end

    // Bus domain: flop chain, then an edge detector.
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge bus_clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= cal_tog;
            end
        end else begin : g_next
            always_ff @(posedge bus_clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign refresh_o = sync_q[SYNC_STAGES-1] & ~last_q;

    // R3: each event lasts a single bus cycle
    p_single_pulse_r3: assert property (@(posedge bus_clk) disable iff (!rst_n)
        refresh_o |=> !refresh_o);

endmodule

// File: rtl/cal_hold_fsm.sv
`timescale 1ns/1ps
module cal_hold_fsm
    import cal_sync_pkg::*;
(
    input  logic bus_clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic rd_ss,
    input  logic rd_time,
    input  logic rd_date,
    output logic time_hold_o,
    output logic date_hold_o
);

    hold_state_e state_q, state_d;
    logic        acc_ss, acc_time, acc_date;

    // Reads count toward the hold sequence only with bypass low.
    assign acc_ss   = rd_ss   & ~bypass;
    assign acc_time = rd_time & ~bypass;
    assign acc_date = rd_date & ~bypass;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Transitions T_SS_READ, T_TIME_READ and T_DATE_READ
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN, ST_HOLD_TD, ST_HOLD_D: begin
                if (acc_ss)        state_d = ST_HOLD_TD;
                else if (acc_time) state_d = ST_HOLD_D;
                else if (acc_date) state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // A read also holds the later words in its own cycle.
    always_comb begin
        time_hold_o = 1'b0;
        date_hold_o = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                time_hold_o = acc_ss;
                date_hold_o = acc_ss | acc_time;
            end
            ST_HOLD_TD: begin
                time_hold_o = 1'b1;
                date_hold_o = 1'b1;
            end
            ST_HOLD_D: begin
                time_hold_o = acc_ss;
                date_hold_o = 1'b1;
            end
            default: begin
                time_hold_o = 1'b0;
                date_hold_o = 1'b0;
            end
        endcase
    end

    p_ss_read_holds_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        acc_ss |=> (time_hold_o && date_hold_o));

    p_time_read_state_r7: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (acc_time && !acc_ss) |=> (state_q == ST_HOLD_D));

    p_date_read_opens_r8: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (acc_date && !acc_ss && !acc_time) |=> (state_q == ST_OPEN));

    p_bypass_keeps_state_r10: assert property (@(posedge bus_clk) disable iff (!rst_n)
        bypass |=> $stable(state_q));

endmodule

// File: rtl/cal_shadow_bank.sv
`timescale 1ns/1ps
module cal_shadow_bank #(
    parameter int SS_W   = 16,
    parameter int TIME_W = 24,
    parameter int DATE_W = 24
) (
    input  logic              bus_clk,
    input  logic              rst_n,
    input  logic              refresh,
    input  logic              time_hold,
    input  logic              date_hold,
    input  logic              flag_clr,
    input  logic [SS_W-1:0]   live_ss,
    input  logic [TIME_W-1:0] live_time,
    input  logic [DATE_W-1:0] live_date,
    output logic [SS_W-1:0]   sh_ss,
    output logic [TIME_W-1:0] sh_time,
    output logic [DATE_W-1:0] sh_date,
    output logic              sync_flag
);

    // The subsecond shadow loads on every refresh.
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n)       sh_ss <= '0;
        else if (refresh) sh_ss <= live_ss;
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n)                      sh_time <= '0;
        else if (refresh && !time_hold)  sh_time <= live_time;
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n)                      sh_date <= '0;
        else if (refresh && !date_hold)  sh_date <= live_date;
    end

    // The set wins over a clear in the same cycle.
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n)        sync_flag <= 1'b0;
        else if (refresh)  sync_flag <= 1'b1;
        else if (flag_clr) sync_flag <= 1'b0;
    end

    p_flag_on_refresh_r4: assert property (@(posedge bus_clk) disable iff (!rst_n)
        refresh |=> sync_flag);

    p_flag_clear_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (flag_clr && !refresh) |=> !sync_flag);

    p_time_held_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        time_hold |=> $stable(sh_time));

    p_date_held_r7: assert property (@(posedge bus_clk) disable iff (!rst_n)
        date_hold |=> $stable(sh_date));

    p_ss_follows_r9: assert property (@(posedge bus_clk) disable iff (!rst_n)
        refresh |=> (sh_ss == $past(live_ss)));

endmodule

// File: rtl/cal_shadow_sync.sv
`timescale 1ns/1ps
module cal_shadow_sync
    import cal_sync_pkg::*;
#(
    parameter int SS_W        = 16,
    parameter int TIME_W      = 24,
    parameter int DATE_W      = 24,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              cal_clk,
    input  logic              rst_n,
    input  logic [SS_W-1:0]   live_ss,
    input  logic [TIME_W-1:0] live_time,
    input  logic [DATE_W-1:0] live_date,
    input  logic              bypass,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    input  logic              sync_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sync_flag
);

    logic              refresh;
    logic              time_hold, date_hold;
    logic              rd_ss, rd_time, rd_date;
    logic [SS_W-1:0]   sh_ss;
    logic [TIME_W-1:0] sh_time;
    logic [DATE_W-1:0] sh_date;
    logic [DATA_W-1:0] rd_next;
    word_sel_e         sel;

    assign sel     = word_sel_e'(rd_addr);
    assign rd_ss   = rd_en && (sel == SEL_SUBSEC);
    assign rd_time = rd_en && (sel == SEL_TIME);
    assign rd_date = rd_en && (sel == SEL_DATE);

    cal_refresh_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .bus_clk   (bus_clk),
        .cal_clk   (cal_clk),
        .rst_n     (rst_n),
        .refresh_o (refresh)
    );

    cal_hold_fsm u_fsm (
        .bus_clk     (bus_clk),
        .rst_n       (rst_n),
        .bypass      (bypass),
        .rd_ss       (rd_ss),
        .rd_time     (rd_time),
        .rd_date     (rd_date),
        .time_hold_o (time_hold),
        .date_hold_o (date_hold)
    );

    cal_shadow_bank #(.SS_W(SS_W), .TIME_W(TIME_W), .DATE_W(DATE_W)) u_bank (
        .bus_clk   (bus_clk),
        .rst_n     (rst_n),
        .refresh   (refresh),
        .time_hold (time_hold),
        .date_hold (date_hold),
        .flag_clr  (sync_clr),
        .live_ss   (live_ss),
        .live_time (live_time),
        .live_date (live_date),
        .sh_ss     (sh_ss),
        .sh_time   (sh_time),
        .sh_date   (sh_date),
        .sync_flag (sync_flag)
    );

    // Read mux: a zero-extended word from the shadows or the live inputs.
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_SUBSEC: rd_next[SS_W-1:0]   = bypass ? live_ss   : sh_ss;
            SEL_TIME:   rd_next[TIME_W-1:0] = bypass ? live_time : sh_time;
            SEL_DATE:   rd_next[DATE_W-1:0] = bypass ? live_date : sh_date;
            SEL_NONE:   rd_next = '0;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    p_bypass_live_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (rd_ss && bypass) |=> (rd_data[SS_W-1:0] == $past(live_ss)));

    p_none_zero_r1: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rd_data == '0));

endmodule

// File: tb/cal_shadow_sync_tb_top.sv
`timescale 1ns/1ps
module cal_shadow_sync_tb_top;

    logic        bus_clk = 1'b0;
    logic        cal_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic [15:0] live_ss = '0;
    logic [23:0] live_time = '0;
    logic [23:0] live_date = '0;
    logic        bypass = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic        sync_clr = 1'b0;
    logic [31:0] rd_data;
    logic        sync_flag;

    int n_vec  = 0;
    int n_fail = 0;
    int k      = 0;
    int edge_n = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [15:0] m_ss = '0;
    logic [23:0] m_time = '0;
    logic [23:0] m_date = '0;
    bit          m_flag = 1'b0;
    int          m_state = 0;   // 0 open, 1 time+date held, 2 date held

    always #2.5 bus_clk = ~bus_clk;

    cal_shadow_sync dut_i (
        .bus_clk   (bus_clk),
        .cal_clk   (cal_clk),
        .rst_n     (rst_n),
        .live_ss   (live_ss),
        .live_time (live_time),
        .live_date (live_date),
        .bypass    (bypass),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .sync_clr  (sync_clr),
        .rd_data   (rd_data),
        .sync_flag (sync_flag)
    );

    function automatic logic [31:0] exp_read(input logic [1:0] a, input bit byp);
        logic [31:0] v = '0;
        case (a)
            2'd0: v[15:0] = byp ? live_ss   : m_ss;
            2'd1: v[23:0] = byp ? live_time : m_time;
            2'd2: v[23:0] = byp ? live_date : m_date;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (k=%0d)", tag, act, exp, k);
        end
    endtask

    // One bus cycle, driven at the falling edge and checked at the next falling edge.
    task automatic step(input bit re, input logic [1:0] a, input bit clr, input string tag);
        int          ph = k % 16;
        bit          evt, acc, hold_t, hold_d;
        logic [31:0] exp;
        cal_clk = (ph < 8);
        if (ph == 0) begin
            edge_n++;
            live_ss   = live_ss + 16'd1;
            live_time = 24'($urandom);
            live_date = 24'($urandom);
        end
        rd_en = re; rd_addr = a; sync_clr = clr;
        // R3: refresh loads three bus cycles after every odd slow edge
        evt    = (ph == 2) && (edge_n % 2 == 1);
        acc    = re && !bypass;
        exp    = exp_read(a, bypass);
        hold_t = (m_state == 1) || (acc && a == 2'd0);
        hold_d = (m_state != 0) || (acc && (a == 2'd0 || a == 2'd1));
        if (evt) begin
            m_ss = live_ss;
            if (!hold_t) m_time = live_time;
            if (!hold_d) m_date = live_date;
        end
        if (evt) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        if (acc) begin
            if (a == 2'd0)      m_state = 1;
            else if (a == 2'd1) m_state = 2;
            else if (a == 2'd2) m_state = 0;
        end
        @(posedge bus_clk);
        @(negedge bus_clk);
        check("R4/R5 sync_flag", {31'd0, sync_flag}, {31'd0, m_flag});
        if (re) check(tag, rd_data, exp);
        k++;
    endtask

    task automatic idle_to(input int target);
        while ((k % 32) != target) step(1'b0, 2'd0, 1'b0, "idle");
    endtask

    initial begin
        void'($urandom(32'd20240607));
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge bus_clk);
        // R11: reset values
        check("R11 rd_data reset", rd_data, 32'd0);
        check("R11 sync_flag reset", {31'd0, sync_flag}, 32'd0);
        rst_n = 1'b1;
        // R11: shadows start at zero and nothing is held
        step(1'b1, 2'd1, 1'b0, "R11 time shadow zero");
        step(1'b1, 2'd2, 1'b0, "R11 date shadow zero");

        // R6: subsecond read in the very refresh cycle holds time and date
        idle_to(2);
        step(1'b1, 2'd0, 1'b0, "R6 ss read on refresh");
        idle_to(10);
        step(1'b1, 2'd1, 1'b0, "R6 time held");
        step(1'b1, 2'd2, 1'b0, "R8 date held then opened");

        // R4: clear in the refresh cycle loses to the set
        idle_to(2);
        step(1'b0, 2'd0, 1'b1, "R4 set wins");
        idle_to(12);
        step(1'b0, 2'd0, 1'b1, "R5 clear");
        idle_to(20);

        // R9: subsecond keeps updating while time and date are held
        step(1'b1, 2'd0, 1'b0, "R6 start group");
        idle_to(8);
        step(1'b1, 2'd0, 1'b0, "R9 ss refreshed");
        step(1'b1, 2'd2, 1'b0, "R6 date frozen");
        idle_to(8);

        // R7: a time read holds only the date word
        step(1'b1, 2'd1, 1'b0, "R7 time read");
        idle_to(8);
        step(1'b1, 2'd1, 1'b0, "R7 time refreshed");
        step(1'b1, 2'd2, 1'b0, "R7 date frozen");

        // R8: a date read in the refresh cycle still skips the date word
        step(1'b1, 2'd1, 1'b0, "R7 rearm");
        idle_to(2);
        step(1'b1, 2'd2, 1'b0, "R8 date read on refresh");
        idle_to(8);
        step(1'b1, 2'd2, 1'b0, "R8 date still old");
        idle_to(8);
        step(1'b1, 2'd2, 1'b0, "R8 date open again");

        // R2, R10: bypass reads see live words and leave holds alone
        bypass = 1'b1;
        step(1'b1, 2'd0, 1'b0, "R2 bypass ss");
        step(1'b1, 2'd1, 1'b0, "R2 bypass time");
        step(1'b1, 2'd2, 1'b0, "R2 bypass date");
        step(1'b1, 2'd3, 1'b0, "R1 none reads zero");
        bypass = 1'b0;
        idle_to(8);
        step(1'b1, 2'd1, 1'b0, "R10 time not held");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            bit          re  = ($urandom % 10) < 4;
            logic [1:0]  a   = 2'($urandom);
            bit          clr = ($urandom % 10) == 0;
            if (($urandom % 20) == 0) bypass = ~bypass;
            step(re, a, clr, bypass ? "R2 random read" : "R1 random read");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule